// File: doc/BRIEF.md
# Multicycle Issue Hazard Interlock

This block is the interlock at the decode/issue stage of an in-order pipeline whose functional units take different numbers of cycles: integer ALU 1, data memory 2, floating-point add 4, floating-point multiply 7 and floating-point divide 25. Each cycle decode presents one instruction: a valid bit, a unit class, a destination register and two source registers. The block answers with one `stall` decision, and asserts `issue` when the instruction leaves decode. An instruction that stalls stays in decode and is presented again in the next cycle.

The block keeps three pieces of state. The first is a countdown for each register of the cycles until its pending result can be forwarded. The second is a reservation shift register that records which future cycles already hold the register-file write port. The third is a two-state machine for the non-pipelined divider, with the states `DIV_IDLE` and `DIV_BUSY`. The machine goes from `DIV_IDLE` to `DIV_BUSY` when a divide issues, and from `DIV_BUSY` back to `DIV_IDLE` when its countdown runs out after the initiation interval. The block stalls on a read-after-write (RAW) hazard, a write-after-write (WAW) hazard, a write-port collision and a busy divider. All hazards are resolved at issue. Time-driven state, meaning the countdowns and the reservation shift, advances every cycle. New entries are recorded only for an instruction that issues.

Top module: `issue_interlock`

## Requirements
- R1: After synchronous reset, no pending register, write-port reservation or divider activity remains, so any valid instruction issues at once.
- R2: `stall` is low whenever `in_valid` is low, and `issue` equals `in_valid` and not `stall`.
- R3: A consumer of a register written by an instruction of latency L that issued k cycles earlier stalls while k < L. An ALU result therefore needs no stall, and a load result costs one stall cycle.
- R4: The stall on a source clears exactly when its countdown reaches zero. A multiply consumer issues 7 cycles after the multiply.
- R5: A write to a register stalls while an older in-flight write to the same register would complete in the same cycle as the new write or later.
- R6: An instruction whose writeback cycle (issue cycle plus latency) equals that of an in-flight instruction stalls.
- R7: A divide stalls while the divider is busy. A second divide can issue no earlier than 25 cycles after the first.
- R8: Register 0 never causes a hazard as a source or destination. A write to it records no pending count and claims no write-port slot.
- R9: A cycle with `in_valid` low, or with `stall` high, records no pending write, reservation or divider activity.
- R10: Unit codes are ALU=0, MEM=1, FADD=2, FMUL=3, FDIV=4. Codes 5 to 7 behave as ALU (latency 1).
- R11: Reset asserted while instructions are in flight clears all of their tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decode holds an instruction |
| in_unit | input | 3 | Functional-unit class (R10 encoding) |
| in_dst | input | 5 | Destination register, 0 means none |
| in_src_a | input | 5 | First source register, 0 means none |
| in_src_b | input | 5 | Second source register, 0 means none |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | The instruction leaves decode this cycle |

## Verification
Four properties are checked on every cycle by the assertions. No issue ever books a write-port slot that is already taken, and no issue ever records register 0. No divide starts outside `DIV_IDLE`, and the divider state machine releases on its final count. No issued instruction overlaps a pending source or an older write to its destination. The exact cycle in which each stall clears can only be shown by the bench's scenarios. Those scenarios cover the multiply-to-ALU gap, the single load stall, the divide interval and the write-port slip. The bench also shows that invalid or stalled requests leave no trace, and that reset clears in-flight state.

// File: rtl/ii_pkg.sv
package ii_pkg;
    typedef enum logic [2:0] {
        UNIT_ALU  = 3'd0,
        UNIT_MEM  = 3'd1,
        UNIT_FADD = 3'd2,
        UNIT_FMUL = 3'd3,
        UNIT_FDIV = 3'd4
    } unit_e;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_BUSY = 1'b1
    } div_state_e;
endpackage

// File: rtl/ii_scoreboard.sv
module ii_scoreboard #(
    parameter int NREGS = 32,
    parameter int CW    = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_en,
    input  logic [$clog2(NREGS)-1:0] set_idx,
    input  logic [CW-1:0]            set_lat,
    input  logic [$clog2(NREGS)-1:0] rd_a_idx,
    input  logic [$clog2(NREGS)-1:0] rd_b_idx,
    input  logic [$clog2(NREGS)-1:0] rd_d_idx,
    output logic [CW-1:0]            rd_a_cnt,
    output logic [CW-1:0]            rd_b_cnt,
    output logic [CW-1:0]            rd_d_cnt
);
    logic [CW-1:0] cnt [NREGS];

    // register 0 holds no pending write
    assign cnt[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (set_en && (set_idx == g)) begin
                cnt[g] <= set_lat - CW'(1);
            end else if (cnt[g] != '0) begin
                cnt[g] <= cnt[g] - CW'(1);
            end
        end
    end

    assign rd_a_cnt = cnt[rd_a_idx];
    assign rd_b_cnt = cnt[rd_b_idx];
    assign rd_d_cnt = cnt[rd_d_idx];

    // R8
    no_r0_track_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |-> (set_idx != '0));
endmodule

// File: rtl/ii_wport.sv
module ii_wport #(
    parameter int RES_DEPTH = 32,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          claim,
    input  logic [CW-1:0] lat,
    output logic          taken
);
    logic [RES_DEPTH-1:0] res_q;
    logic [RES_DEPTH-1:0] res_d;
    logic [RES_DEPTH-1:0] one_hot;

    assign taken = res_q[lat];

    always_comb begin
        one_hot = '0;
        one_hot[lat - CW'(1)] = claim;
        res_d = (res_q >> 1) | one_hot;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    // R6
    no_port_clash_chk: assert property (@(posedge clk) disable iff (rst)
        claim |-> !res_q[lat]);
endmodule

// File: rtl/ii_div_fsm.sv
module ii_div_fsm
    import ii_pkg::*;
#(
    parameter int DIV_II = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int DW = $clog2(DIV_II + 1);

    div_state_e    state_q;
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                DIV_IDLE: if (start) begin
                    state_q <= DIV_BUSY;
                    cnt_q   <= DW'(DIV_II - 1);
                end
                DIV_BUSY: begin
                    cnt_q <= cnt_q - DW'(1);
                    if (cnt_q == DW'(1)) state_q <= DIV_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            DIV_IDLE: busy = 1'b0;
            DIV_BUSY: busy = 1'b1;
        endcase
    end

    // R7
    no_div_reissue_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (state_q == DIV_IDLE));
    // R7
    div_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIV_BUSY && cnt_q == DW'(1)) |=> (state_q == DIV_IDLE));
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
    import ii_pkg::*;
#(
    parameter int NREGS     = 32,
    parameter int RES_DEPTH = 32,
    parameter int LAT_ALU   = 1,
    parameter int LAT_MEM   = 2,
    parameter int LAT_FADD  = 4,
    parameter int LAT_FMUL  = 7,
    parameter int LAT_FDIV  = 25,
    parameter int DIV_II    = 25
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [2:0]               in_unit,
    input  logic [$clog2(NREGS)-1:0] in_dst,
    input  logic [$clog2(NREGS)-1:0] in_src_a,
    input  logic [$clog2(NREGS)-1:0] in_src_b,
    output logic                     stall,
    output logic                     issue
);
    localparam int CW = $clog2(RES_DEPTH);

    logic [CW-1:0] lat;
    logic          is_div;
    logic          writes;
    logic [CW-1:0] cnt_a, cnt_b, cnt_d;
    logic          port_taken, div_busy;
    logic          raw_hz, waw_hz, port_hz, div_hz;

    always_comb begin
        is_div = 1'b0;
        unique case (in_unit)
            UNIT_MEM:  lat = CW'(LAT_MEM);
            UNIT_FADD: lat = CW'(LAT_FADD);
            UNIT_FMUL: lat = CW'(LAT_FMUL);
            UNIT_FDIV: begin lat = CW'(LAT_FDIV); is_div = 1'b1; end
            default:   lat = CW'(LAT_ALU);
        endcase
    end

    assign writes  = (in_dst != '0);
    assign raw_hz  = (cnt_a != '0) || (cnt_b != '0);
    assign waw_hz  = writes && (cnt_d >= lat);
    assign port_hz = writes && port_taken;
    assign div_hz  = is_div && div_busy;
    assign stall   = in_valid && (raw_hz || waw_hz || port_hz || div_hz);
    assign issue   = in_valid && !stall;

    ii_scoreboard #(.NREGS(NREGS), .CW(CW)) u_sb (
        .clk(clk), .rst(rst),
        .set_en(issue && writes), .set_idx(in_dst), .set_lat(lat),
        .rd_a_idx(in_src_a), .rd_b_idx(in_src_b), .rd_d_idx(in_dst),
        .rd_a_cnt(cnt_a), .rd_b_cnt(cnt_b), .rd_d_cnt(cnt_d)
    );

    ii_wport #(.RES_DEPTH(RES_DEPTH), .CW(CW)) u_wp (
        .clk(clk), .rst(rst),
        .claim(issue && writes), .lat(lat), .taken(port_taken)
    );

    ii_div_fsm #(.DIV_II(DIV_II)) u_div (
        .clk(clk), .rst(rst),
        .start(issue && is_div), .busy(div_busy)
    );

    // R2
    stall_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> in_valid);
    // R3
    no_raw_issue_chk: assert property (@(posedge clk) disable iff (rst)
        issue |-> (cnt_a == '0 && cnt_b == '0));
    // R5
    no_waw_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && writes) |-> (cnt_d < lat));
endmodule

// File: tb/tb_issue_interlock.sv
module tb_issue_interlock;
    localparam int CYC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] in_unit = 3'd0;
    logic [4:0] in_dst = 5'd0, in_src_a = 5'd0, in_src_b = 5'd0;
    logic       stall, issue;

    int total = 0;
    int bad   = 0;

    always #(CYC/2) clk = ~clk;

    issue_interlock dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .stall(stall), .issue(issue)
    );

    // {req[3:0], valid, unit[2:0], dst, src_a, src_b, exp_stall}
    localparam logic [23:0] VEC [33] = '{
        {4'd1, 1'b1, 3'd3, 5'd3,  5'd0,  5'd0, 1'b0}, // R1 FMUL r3
        {4'd3, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b1}, // R3
        {4'd3, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b1},
        {4'd3, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b1},
        {4'd3, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b1},
        {4'd3, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b1},
        {4'd3, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b1},
        {4'd4, 1'b1, 3'd0, 5'd4,  5'd3,  5'd0, 1'b0}, // R4 7 cycles after
        {4'd3, 1'b1, 3'd0, 5'd5,  5'd4,  5'd0, 1'b0}, // R3 ALU to ALU
        {4'd10,1'b1, 3'd1, 5'd6,  5'd0,  5'd0, 1'b0}, // R10 load
        {4'd3, 1'b1, 3'd0, 5'd7,  5'd6,  5'd0, 1'b1}, // R3 load use
        {4'd3, 1'b1, 3'd0, 5'd7,  5'd6,  5'd0, 1'b0},
        {4'd6, 1'b1, 3'd2, 5'd8,  5'd0,  5'd0, 1'b0}, // R6 FADD wb +4
        {4'd2, 1'b0, 3'd0, 5'd0,  5'd0,  5'd0, 1'b0}, // R2 bubble
        {4'd6, 1'b1, 3'd1, 5'd9,  5'd0,  5'd0, 1'b1}, // R6 same wb
        {4'd6, 1'b1, 3'd1, 5'd9,  5'd0,  5'd0, 1'b0},
        {4'd5, 1'b1, 3'd3, 5'd10, 5'd0,  5'd0, 1'b0}, // R5 FMUL r10
        {4'd5, 1'b1, 3'd0, 5'd10, 5'd0,  5'd0, 1'b1}, // R5 ALU r10
        {4'd5, 1'b1, 3'd2, 5'd10, 5'd0,  5'd0, 1'b1}, // R5 FADD r10
        {4'd5, 1'b1, 3'd0, 5'd11, 5'd0,  5'd0, 1'b0},
        {4'd8, 1'b1, 3'd3, 5'd0,  5'd0,  5'd0, 1'b0}, // R8 FMUL r0
        {4'd8, 1'b1, 3'd0, 5'd12, 5'd0,  5'd0, 1'b0},
        {4'd2, 1'b0, 3'd0, 5'd0,  5'd0,  5'd0, 1'b0},
        {4'd8, 1'b1, 3'd2, 5'd14, 5'd0,  5'd0, 1'b0}, // R8 no slot held
        {4'd8, 1'b1, 3'd0, 5'd0,  5'd0,  5'd0, 1'b0},
        {4'd9, 1'b0, 3'd3, 5'd15, 5'd0,  5'd0, 1'b0}, // R9 invalid FMUL
        {4'd9, 1'b1, 3'd1, 5'd16, 5'd15, 5'd0, 1'b0},
        {4'd9, 1'b1, 3'd3, 5'd17, 5'd0,  5'd0, 1'b0},
        {4'd9, 1'b1, 3'd3, 5'd18, 5'd17, 5'd0, 1'b1}, // R9 stalled FMUL
        {4'd9, 1'b1, 3'd0, 5'd19, 5'd18, 5'd0, 1'b0},
        {4'd2, 1'b0, 3'd0, 5'd20, 5'd17, 5'd0, 1'b0}, // R2 invalid hazard
        {4'd7, 1'b1, 3'd4, 5'd21, 5'd0,  5'd0, 1'b0}, // R7 FDIV
        {4'd7, 1'b1, 3'd4, 5'd22, 5'd0,  5'd0, 1'b1}
    };

    task automatic step(input logic v, input logic [2:0] u, input logic [4:0] d,
                        input logic [4:0] a, input logic [4:0] b,
                        input logic exp, input int req);
        @(negedge clk);
        in_valid = v; in_unit = u; in_dst = d; in_src_a = a; in_src_b = b;
        #1;
        total++;
        if (stall !== exp || issue !== (v && !exp)) begin
            bad++;
            $display("FAIL R%0d: stall=%b issue=%b expected stall=%b issue=%b",
                     req, stall, issue, exp, v && !exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CYC * 100000);
        bad++;
        $display("FAIL watchdog: run did not end");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 idle after reset
        step(1'b0, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1);

        for (int i = 0; i < 33; i++) begin
            step(VEC[i][19], VEC[i][18:16], VEC[i][15:11], VEC[i][10:6],
                 VEC[i][5:1], VEC[i][0], int'(VEC[i][23:20]));
        end

        // R7 divide interval: second FDIV waits until 25 cycles after the first
        for (int k = 2; k < 25; k++) step(1'b1, 3'd4, 5'd22, 5'd0, 5'd0, 1'b1, 7);
        step(1'b1, 3'd4, 5'd22, 5'd0, 5'd0, 1'b0, 7);

        // R10 unknown code acts as latency 1
        do_reset();
        step(1'b1, 3'd1, 5'd3, 5'd0, 5'd0, 1'b0, 10);
        step(1'b1, 3'd7, 5'd4, 5'd0, 5'd0, 1'b1, 10);
        step(1'b1, 3'd7, 5'd4, 5'd3, 5'd0, 1'b0, 10);
        step(1'b1, 3'd0, 5'd5, 5'd4, 5'd0, 1'b0, 10);

        // R11 reset in flight
        step(1'b1, 3'd4, 5'd6, 5'd0, 5'd0, 1'b0, 11);
        step(1'b1, 3'd3, 5'd7, 5'd0, 5'd0, 1'b0, 11);
        do_reset();
        step(1'b1, 3'd4, 5'd8, 5'd7, 5'd0, 1'b0, 11);
        step(1'b1, 3'd3, 5'd9, 5'd0, 5'd8, 1'b1, 11);

        @(negedge clk);
        in_valid = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule